// File: doc/BRIEF.md
# ADC conversion sequencer and trigger control

This block is the digital control that sits beside a successive-approximation converter. It holds two byte-wide control registers and derives a one-cycle ADC clock enable from the system clock through a selectable power-of-two prescaler. It launches conversions either once on a software command or automatically on the rising edge of a chosen event flag. It also keeps the end-of-conversion flag and drives an interrupt request from it.

A small state machine sequences each conversion. There are three states. `S_IDLE` waits for a launch. `S_START` drives a one-cycle `conv_start` pulse to the analog core. `S_CONVERT` waits for `conv_done`. The transitions are:

- IDLE->START: on a software start write, or on a selected event edge while auto mode is on.
- START->CONVERT: taken unconditionally.
- CONVERT->IDLE: on `conv_done`. This transition also sets the completion flag.

Control register A sits at `reg_addr` 0:

| Bits | Field |
|------|-------|
| bit0 | start / busy |
| bit1 | auto-trigger enable |
| bit2 | interrupt enable |
| bit3 | completion flag |
| bits6:4 | prescaler code |
| bit7 | reads 0 |

Control register B sits at `reg_addr` 1:

| Bits | Field |
|------|-------|
| bit0 | high-speed mode |
| bits4:1 | event source select |
| bits7:5 | read 0 |

Top module: `adc_seq_ctrl`

## Requirements
- R1: The prescaler code in register A bits6:4 sets the `adc_clk_en` period. Codes 0 and 1 give 2 cycles, and codes 2 to 7 give 4, 8, 16, 32, 64 and 128 cycles. After reset the period is 2 cycles.
- R2: `adc_clk_en` is high for exactly one system clock per period. A new code takes effect only at the next counter wrap.
- R3: Writing register A with bit0=1 while idle makes `conv_start` high for exactly one cycle, in the cycle after the write. Bit0 then reads 1 until the conversion ends, and reads 0 after that.
- R4: The completion flag (register A bit3) becomes 1 in the cycle after `conv_done` arrives during a conversion.
- R5: The completion flag clears on `irq_ack` or on a write to register A with bit3=1. A write with bit3=0 leaves the flag unchanged.
- R6: `irq` is high exactly when the completion flag is 1 and the interrupt-enable bit (register A bit2) is 1.
- R7: With auto mode on (register A bit1=1), a rising edge on `event_flags[sel]` launches one conversion, where sel is register B bits4:1. Edges on other flags do nothing. A flag held high does not launch again.
- R8: With auto mode off, event flags and the source select launch no conversion.
- R9: An event edge that arrives while a conversion is in progress is dropped and not queued.
- R10: Register B bit0 drives `adc_hs_mode`. Both registers read 0 after reset, and the unused bits of register B read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control A, 1 = control B |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| event_flags | input | 16 | Event flags that can serve as trigger sources |
| conv_done | input | 1 | End-of-conversion pulse from the analog core |
| irq_ack | input | 1 | Interrupt acknowledge |
| conv_start | output | 1 | One-cycle start pulse to the analog core |
| adc_clk_en | output | 1 | ADC clock enable pulse |
| adc_hs_mode | output | 1 | High-speed mode to the analog core |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The hardest case to reach is a trigger edge that lands inside a conversion that is already running.

To reach it, the bench lengthens its converter model's latency and then starts a conversion from an event edge. It drops and raises the same flag again while `conv_done` is still pending. It then counts `conv_start` pulses over a window long enough to catch any queued launch.

A second difficult case is the moment a new prescaler code takes effect. This is observed by skipping the first period after the write and measuring the steady-state period that follows.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_START   = 2'd1,
        S_CONVERT = 2'd2
    } conv_state_t;

    // register A bit positions
    localparam int RA_GO    = 0;
    localparam int RA_AUTO  = 1;
    localparam int RA_IE    = 2;
    localparam int RA_FLAG  = 3;
    localparam int RA_PS_LO = 4;
    // register B bit positions
    localparam int RB_HS     = 0;
    localparam int RB_SEL_LO = 1;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W = (2 ** SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] lim_new;
    logic [CNT_W:0]   span;
    logic [SEL_W-1:0] shift;

    always_comb begin
        shift   = (code == '0) ? SEL_W'(1) : code;
        span    = (CNT_W + 1)'(1) << shift;
        lim_new = CNT_W'(span - 1'b1);
    end

    assign tick = (cnt_q == lim_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= CNT_W'(1);
        end else if (tick) begin
            cnt_q <= '0;
            lim_q <= lim_new;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_edge_pick.sv
module adc_edge_pick #(
    parameter int N_EVT = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    localparam int SPAN = 2 ** SEL_W;

    logic [N_EVT-1:0] prev_q;
    logic [N_EVT-1:0] rise;
    logic [SPAN-1:0]  rise_pad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt;
    end

    assign rise = evt & ~prev_q;

    generate
        if (N_EVT >= SPAN) begin : g_full
            assign rise_pad = rise[SPAN-1:0];
        end else begin : g_pad
            assign rise_pad = {{(SPAN - N_EVT){1'b0}}, rise};
        end
    endgenerate

    assign hit = rise_pad[sel];
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
#(
    parameter int PS_W  = 3,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             finish,
    input  logic             ack,
    input  logic             busy,
    output logic             start_req,
    output logic             auto_en,
    output logic             int_en,
    output logic             flag,
    output logic [PS_W-1:0]  ps_code,
    output logic             hs_mode,
    output logic [SEL_W-1:0] src_sel
);
    logic       wr_a;
    logic       wr_b;
    logic [7:0] reg_a_view;
    logic [7:0] reg_b_view;
    logic       unused_bits;

    assign wr_a        = wr_en && !addr;
    assign wr_b        = wr_en && addr;
    assign start_req   = wr_a && wdata[RA_GO];
    assign unused_bits = ^{wdata[7:RA_PS_LO+PS_W], wdata[7:RB_SEL_LO+SEL_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_en <= 1'b0;
            int_en  <= 1'b0;
            ps_code <= '0;
        end else if (wr_a) begin
            auto_en <= wdata[RA_AUTO];
            int_en  <= wdata[RA_IE];
            ps_code <= wdata[RA_PS_LO +: PS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_mode <= 1'b0;
            src_sel <= '0;
        end else if (wr_b) begin
            hs_mode <= wdata[RB_HS];
            src_sel <= wdata[RB_SEL_LO +: SEL_W];
        end
    end

    // set has priority over any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (finish)                         flag <= 1'b1;
        else if (ack || (wr_a && wdata[RA_FLAG])) flag <= 1'b0;
    end

    always_comb begin
        reg_a_view                      = '0;
        reg_a_view[RA_GO]               = busy;
        reg_a_view[RA_AUTO]             = auto_en;
        reg_a_view[RA_IE]               = int_en;
        reg_a_view[RA_FLAG]             = flag;
        reg_a_view[RA_PS_LO +: PS_W]    = ps_code;
        reg_b_view                      = '0;
        reg_b_view[RB_HS]               = hs_mode;
        reg_b_view[RB_SEL_LO +: SEL_W]  = src_sel;
        rdata = addr ? reg_b_view : reg_a_view;
    end
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        trig_hit,
    input  logic        auto_en,
    input  logic        conv_done,
    output logic        conv_start,
    output logic        busy,
    output logic        converting,
    output logic        finish
);
    conv_state_t state_q;
    conv_state_t state_d;
    logic        launch;

    assign launch = start_req || (auto_en && trig_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (launch) state_d = S_START;
            S_START:   state_d = S_CONVERT;
            S_CONVERT: if (conv_done) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        conv_start = (state_q == S_START);
        converting = (state_q == S_CONVERT);
        busy       = (state_q != S_IDLE);
        finish     = converting && conv_done;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int N_EVT = 16,
    parameter int PS_W  = 3,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [N_EVT-1:0] event_flags,
    input  logic             conv_done,
    input  logic             irq_ack,
    output logic             conv_start,
    output logic             adc_clk_en,
    output logic             adc_hs_mode,
    output logic             irq
);
    logic             start_req;
    logic             auto_en;
    logic             int_en;
    logic             flag_w;
    logic [PS_W-1:0]  ps_code;
    logic [SEL_W-1:0] src_sel;
    logic             trig_hit;
    logic             busy;
    logic             st_convert;
    logic             finish;

    adc_ctrl_regs #(.PS_W(PS_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .finish(finish), .ack(irq_ack),
        .busy(busy), .start_req(start_req), .auto_en(auto_en), .int_en(int_en),
        .flag(flag_w), .ps_code(ps_code), .hs_mode(adc_hs_mode), .src_sel(src_sel)
    );

    adc_prescaler #(.SEL_W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .code(ps_code), .tick(adc_clk_en)
    );

    adc_edge_pick #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt(event_flags), .sel(src_sel), .hit(trig_hit)
    );

    adc_conv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .trig_hit(trig_hit),
        .auto_en(auto_en), .conv_done(conv_done), .conv_start(conv_start),
        .busy(busy), .converting(st_convert), .finish(finish)
    );

    assign irq = flag_w && int_en;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic conv_done,
    input logic irq_ack,
    input logic adc_clk_en,
    input logic in_convert,
    input logic done_flag
);
    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_convert |=> !conv_start);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_convert && conv_done) |=> done_flag);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(in_convert && conv_done)) |=> !done_flag);

    // R2
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_clk_en |=> !adc_clk_en);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .irq_ack(irq_ack), .adc_clk_en(adc_clk_en), .in_convert(st_convert),
    .done_flag(flag_w)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] event_flags = '0;
    logic        conv_done = 1'b0;
    logic        irq_ack = 1'b0;
    logic        conv_start;
    logic        adc_clk_en;
    logic        adc_hs_mode;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int lat = 6;
    int cd_cnt = 0;
    int start_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_flags(event_flags),
        .conv_done(conv_done), .irq_ack(irq_ack), .conv_start(conv_start),
        .adc_clk_en(adc_clk_en), .adc_hs_mode(adc_hs_mode), .irq(irq)
    );

    // converter model: fixed latency after each start pulse
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) start_cnt <= start_cnt + 1;
        if (cd_cnt > 0) begin
            cd_cnt <= cd_cnt - 1;
            if (cd_cnt == 1) conv_done <= 1'b1;
        end else if (conv_start) begin
            cd_cnt <= lat;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] a_val(input bit go, input bit au, input bit ie,
                                         input bit clr, input int ps);
        return {1'b0, 3'(ps), clr, ie, au, go};
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd_b(output logic [7:0] v);
        @(negedge clk);
        reg_addr = 1'b1;
        #1 v = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] vb;
        chk("R10 reg A reset", int'(reg_rdata), 0);
        rd_b(vb);
        chk("R10 reg B reset", int'(vb), 0);
        chk("R6 irq reset", int'(irq), 0);
        chk("R3 conv_start reset", int'(conv_start), 0);
    endtask

    task automatic t_prescale();
        int exp, n;
        for (int c = 0; c < 8; c++) begin
            wr(1'b0, a_val(0, 0, 0, 0, c));
            exp = (c == 0) ? 2 : (1 << c);
            for (int k = 0; k < 2; k++) begin
                n = 0;
                while (!adc_clk_en && n < 300) begin @(negedge clk); n++; end
                n = 0;
                do begin
                    @(negedge clk); n++;
                    if (n == 1) chk("R2 pulse width", int'(adc_clk_en), 0);
                end while (!adc_clk_en && n < 300);
            end
            chk($sformatf("R1 R11 period code %0d", c), n, exp);
        end
        wr(1'b0, a_val(0, 0, 0, 0, 0));
    endtask

    task automatic t_single();
        int s0 = start_cnt;
        wr(1'b0, a_val(1, 0, 0, 1, 0));
        chk("R3 start pulse", int'(conv_start), 1);
        chk("R3 busy reads 1", int'(reg_rdata[0]), 1);
        @(negedge clk);
        chk("R3 pulse one cycle", int'(conv_start), 0);
        idle_wait(lat + 4);
        chk("R3 busy clears", int'(reg_rdata[0]), 0);
        chk("R4 flag set", int'(reg_rdata[3]), 1);
        chk("R3 one launch", start_cnt - s0, 1);
        chk("R6 irq off when disabled", int'(irq), 0);
    endtask

    task automatic t_flag_write();
        wr(1'b0, a_val(0, 0, 0, 0, 0));
        chk("R5 write 0 keeps flag", int'(reg_rdata[3]), 1);
        wr(1'b0, a_val(0, 0, 0, 1, 0));
        chk("R5 write 1 clears flag", int'(reg_rdata[3]), 0);
    endtask

    task automatic t_irq();
        wr(1'b0, a_val(1, 0, 1, 0, 0));
        chk("R6 no irq while busy", int'(irq), 0);
        idle_wait(lat + 4);
        chk("R6 irq raised", int'(irq), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R5 ack clears flag", int'(reg_rdata[3]), 0);
        chk("R6 irq drops", int'(irq), 0);
    endtask

    task automatic t_auto();
        int s0;
        wr(1'b1, {3'b000, 4'd5, 1'b0});
        wr(1'b0, a_val(0, 1, 0, 1, 0));
        s0 = start_cnt;
        @(negedge clk); event_flags[3] = 1'b1;
        idle_wait(lat + 6);
        chk("R7 other flag ignored", start_cnt - s0, 0);
        event_flags[5] = 1'b1;
        idle_wait(lat + 6);
        chk("R7 selected edge launches", start_cnt - s0, 1);
        chk("R7 R4 flag after auto", int'(reg_rdata[3]), 1);
        idle_wait(30);
        chk("R7 held level no retrigger", start_cnt - s0, 1);
        event_flags = '0;
        idle_wait(2);
    endtask

    task automatic t_auto_off();
        int s0;
        wr(1'b0, a_val(0, 0, 0, 1, 0));
        s0 = start_cnt;
        @(negedge clk); event_flags[5] = 1'b1;
        idle_wait(lat + 6);
        chk("R8 no launch when off", start_cnt - s0, 0);
        chk("R8 flag stays clear", int'(reg_rdata[3]), 0);
        event_flags = '0;
        idle_wait(2);
    endtask

    task automatic t_busy_drop();
        int s0;
        lat = 30;
        wr(1'b0, a_val(0, 1, 0, 1, 0));
        s0 = start_cnt;
        @(negedge clk); event_flags[5] = 1'b1;
        idle_wait(6);
        event_flags[5] = 1'b0;
        idle_wait(2);
        event_flags[5] = 1'b1;
        idle_wait(80);
        chk("R9 edge during conversion dropped", start_cnt - s0, 1);
        event_flags = '0;
        lat = 6;
        wr(1'b0, a_val(0, 0, 0, 1, 0));
    endtask

    task automatic t_hs();
        logic [7:0] vb;
        wr(1'b1, 8'h01);
        chk("R10 hs output", int'(adc_hs_mode), 1);
        wr(1'b1, 8'hFF);
        rd_b(vb);
        chk("R10 reg B unused bits", int'(vb), 'h1F);
        wr(1'b1, 8'h00);
        chk("R10 hs cleared", int'(adc_hs_mode), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_single();
        t_flag_write();
        t_irq();
        t_auto();
        t_auto_off();
        t_busy_drop();
        t_hs();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule